// File: doc/BRIEF.md
# Two-Wire Bus Condition Control Register

This block is the control and status byte of a two-wire serial bus port. Software uses it to put start and stop conditions on the bus. A start trigger pulls the serial-output latch low and a stop trigger releases it high. Each trigger bit clears itself once it has moved the latch, so software never has to clear it.

The block also watches the sampled clock and data lines. It keeps sticky flags for start and stop conditions seen on the bus. Each flag has its own set of protocol events that clear it.

A software acknowledge bit asks the data pin driver to hold the line low. The request lasts until the next falling clock edge. The shift engine, the address comparator and the clock generator sit outside this block. They supply the transfer-start and address-mismatch pulses.

Top module: `twb_cond_ctrl`

## Requirements
- R1: After reset the register reads 0x00, the serial-output latch is 1 and the pull-low request is 0.
- R2: Bit 6 (ack-detected), bit 3 (start-detected) and bit 2 (stop-detected) are read-only. Writes to them have no effect, and bit 6 always reads 0.
- R3: A write with bit 0 (stop trigger) set while the enable is high makes bit 0 read 1 for one cycle. At the next edge the latch becomes 1 and bit 0 returns to 0.
- R4: A write with bit 1 (start trigger) set while the enable is high makes bit 1 read 1 for one cycle. At the next edge the latch becomes 0 and bit 1 returns to 0. If both trigger bits are written together, the stop trigger decides the latch and both bits clear.
- R5: While the enable is low, both trigger bits read 0, writes to them are ignored and the latch keeps its value.
- R6: Bit 2 is set by a stop condition, which is a rising data line while the clock line is high. It becomes visible at the third edge after the lines change, because of two synchronizer stages and the flag itself. It is cleared one edge after a transfer-start pulse, an address-mismatch pulse or a low enable. A clear wins over a set.
- R7: Bit 3 is set by a start condition, which is a falling data line while the clock line is high, with the same latency as R6. It is cleared by a transfer-start pulse, a stop condition or a low enable. A clear wins over a set.
- R8: Writing bit 4 (ack trigger) stores the written value. While the bit is 1, the pull-low request is 1. The bit clears at the third edge after the clock line falls.
- R9: A transfer-start pulse while the enable is low clears bit 4. A transfer-start pulse while the enable is high leaves bit 4 unchanged.
- R10: Bit 7 (busy-enable) and bit 5 (ack-enable) are plain read/write storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Register readback |
| if_en_i | input | 1 | Serial interface enable |
| xfer_start_i | input | 1 | Transfer-start pulse |
| addr_mismatch_i | input | 1 | Address mismatch pulse from address reception |
| scl_i | input | 1 | Sampled clock line |
| sda_i | input | 1 | Sampled data line |
| so_latch_o | output | 1 | Serial-output latch value |
| sda_pull_o | output | 1 | Request to hold the data line low |

## Verification
A register write is visible on the readback one edge after the strobe. A trigger bit moves the latch one edge after that. A transfer-start, mismatch or enable change clears flags one edge later. Line events reach the flags or the ack bit three edges after the pins change. The bench changes every input on a falling clock edge and waits exactly that many falling edges before it samples, so each check lands on the first cycle the result is due. Where a result must not change, the bench samples after the same delay.

// File: rtl/twb_pkg.sv
package twb_pkg;
  localparam int unsigned REG_W          = 8;
  localparam int unsigned BIT_STOP_TRIG  = 0;
  localparam int unsigned BIT_START_TRIG = 1;
  localparam int unsigned BIT_STOP_DET   = 2;
  localparam int unsigned BIT_START_DET  = 3;
  localparam int unsigned BIT_ACK_TRIG   = 4;
  localparam int unsigned BIT_ACK_EN     = 5;
  localparam int unsigned BIT_ACK_DET    = 6;
  localparam int unsigned BIT_BUSY_EN    = 7;

  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } line_evt_t;
endpackage

// File: rtl/twb_line_sync.sv
module twb_line_sync
  import twb_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      line_i,
  output line_evt_t evt_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic          prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[LAST-1:0], line_i};
      prev_q  <= chain_q[LAST];
    end
  end

  assign evt_o.lvl  = chain_q[LAST];
  assign evt_o.rise = chain_q[LAST] & ~prev_q;
  assign evt_o.fall = ~chain_q[LAST] & prev_q;
endmodule

// File: rtl/twb_cond_detect.sv
module twb_cond_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic if_en_i,
  input  logic xfer_start_i,
  input  logic addr_mismatch_i,
  input  logic scl_lvl_i,
  input  logic sda_rise_i,
  input  logic sda_fall_i,
  output logic start_det_o,
  output logic stop_det_o
);
  logic start_seen, stop_seen;
  logic start_q, stop_q;

  assign start_seen = scl_lvl_i & sda_fall_i;
  assign stop_seen  = scl_lvl_i & sda_rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      // clear has priority over set
      if (xfer_start_i || addr_mismatch_i || !if_en_i) stop_q <= 1'b0;
      else if (stop_seen)                              stop_q <= 1'b1;

      if (xfer_start_i || stop_seen || !if_en_i) start_q <= 1'b0;
      else if (start_seen)                       start_q <= 1'b1;
    end
  end

  assign start_det_o = start_q;
  assign stop_det_o  = stop_q;
endmodule

// File: rtl/twb_trig_ctrl.sv
module twb_trig_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic if_en_i,
  input  logic wr_en_i,
  input  logic wr_stop_i,
  input  logic wr_start_i,
  input  logic wr_ack_i,
  input  logic xfer_start_i,
  input  logic scl_fall_i,
  output logic stop_trig_o,
  output logic start_trig_o,
  output logic ack_trig_o,
  output logic so_latch_o
);
  logic stop_q, start_q, ack_q, latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q  <= 1'b0;
      start_q <= 1'b0;
      ack_q   <= 1'b0;
      latch_q <= 1'b1;
    end else begin
      // trigger bits live for one cycle, then act and drop
      stop_q  <= if_en_i & wr_en_i & wr_stop_i;
      start_q <= if_en_i & wr_en_i & wr_start_i;

      if (if_en_i) begin
        if (stop_q)       latch_q <= 1'b1;
        else if (start_q) latch_q <= 1'b0;
      end

      if (xfer_start_i && !if_en_i) ack_q <= 1'b0;
      else if (wr_en_i)             ack_q <= wr_ack_i;
      else if (scl_fall_i)          ack_q <= 1'b0;
    end
  end

  assign stop_trig_o  = stop_q;
  assign start_trig_o = start_q;
  assign ack_trig_o   = ack_q;
  assign so_latch_o   = latch_q;
endmodule

// File: rtl/twb_cond_ctrl.sv
module twb_cond_ctrl
  import twb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             if_en_i,
  input  logic             xfer_start_i,
  input  logic             addr_mismatch_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             so_latch_o,
  output logic             sda_pull_o
);
  localparam int unsigned N_LINES = 2;
  localparam int unsigned IDX_SDA = 0;
  localparam int unsigned IDX_SCL = 1;

  logic [N_LINES-1:0] line_in;
  line_evt_t          evt [N_LINES];

  assign line_in = {scl_i, sda_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    twb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(line_in[g]),
      .evt_o (evt[g])
    );
  end

  logic start_det, stop_det;
  logic stop_trig, start_trig, ack_trig;
  logic busy_en_q, ack_en_q;
  logic unused_ro_bits;

  twb_cond_detect u_det (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .if_en_i        (if_en_i),
    .xfer_start_i   (xfer_start_i),
    .addr_mismatch_i(addr_mismatch_i),
    .scl_lvl_i      (evt[IDX_SCL].lvl),
    .sda_rise_i     (evt[IDX_SDA].rise),
    .sda_fall_i     (evt[IDX_SDA].fall),
    .start_det_o    (start_det),
    .stop_det_o     (stop_det)
  );

  twb_trig_ctrl u_trig (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .if_en_i     (if_en_i),
    .wr_en_i     (wr_en_i),
    .wr_stop_i   (wr_data_i[BIT_STOP_TRIG]),
    .wr_start_i  (wr_data_i[BIT_START_TRIG]),
    .wr_ack_i    (wr_data_i[BIT_ACK_TRIG]),
    .xfer_start_i(xfer_start_i),
    .scl_fall_i  (evt[IDX_SCL].fall),
    .stop_trig_o (stop_trig),
    .start_trig_o(start_trig),
    .ack_trig_o  (ack_trig),
    .so_latch_o  (so_latch_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_en_q <= 1'b0;
      ack_en_q  <= 1'b0;
    end else if (wr_en_i) begin
      busy_en_q <= wr_data_i[BIT_BUSY_EN];
      ack_en_q  <= wr_data_i[BIT_ACK_EN];
    end
  end

  assign unused_ro_bits = ^{wr_data_i[BIT_ACK_DET], wr_data_i[BIT_START_DET],
                            wr_data_i[BIT_STOP_DET], evt[IDX_SCL].rise};

  always_comb begin
    rd_data_o                 = '0;
    rd_data_o[BIT_BUSY_EN]    = busy_en_q;
    rd_data_o[BIT_ACK_DET]    = 1'b0;
    rd_data_o[BIT_ACK_EN]     = ack_en_q;
    rd_data_o[BIT_ACK_TRIG]   = ack_trig;
    rd_data_o[BIT_START_DET]  = start_det;
    rd_data_o[BIT_STOP_DET]   = stop_det;
    rd_data_o[BIT_START_TRIG] = start_trig;
    rd_data_o[BIT_STOP_TRIG]  = stop_trig;
  end

  assign sda_pull_o = ack_trig;
endmodule

// File: rtl/twb_cond_ctrl_chk.sv
module twb_cond_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       if_en_i,
  input logic       xfer_start_i,
  input logic       addr_mismatch_i,
  input logic [7:0] rd_data_o,
  input logic       so_latch_o,
  input logic       sda_pull_o
);
  p_ackd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[6]);

  p_stop_trig_act_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[0] && if_en_i) |=> (so_latch_o && !rd_data_o[0]));

  p_start_trig_act_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[1] && !rd_data_o[0] && if_en_i) |=> (!so_latch_o && !rd_data_o[1]));

  p_en_low_trig_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !if_en_i |=> (rd_data_o[1:0] == 2'b00));

  p_en_low_latch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !if_en_i |=> $stable(so_latch_o));

  p_stop_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_start_i || addr_mismatch_i || !if_en_i) |=> !rd_data_o[2]);

  p_start_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_start_i || !if_en_i) |=> !rd_data_o[3]);

  p_start_drop_on_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[2]) |-> !rd_data_o[3]);

  p_ack_xfer_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_start_i && !if_en_i) |=> !sda_pull_o);
endmodule

bind twb_cond_ctrl twb_cond_ctrl_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .if_en_i        (if_en_i),
  .xfer_start_i   (xfer_start_i),
  .addr_mismatch_i(addr_mismatch_i),
  .rd_data_o      (rd_data_o),
  .so_latch_o     (so_latch_o),
  .sda_pull_o     (sda_pull_o)
);

// File: tb/twb_cond_ctrl_tb_top.sv
module twb_cond_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       if_en_i = 1'b0;
  logic       xfer_start_i = 1'b0;
  logic       addr_mismatch_i = 1'b0;
  logic       scl_i = 1'b1;
  logic       sda_i = 1'b1;
  logic       so_latch_o;
  logic       sda_pull_o;

  int total = 0;
  int bad = 0;

  always #5 clk_i = ~clk_i;

  twb_cond_ctrl dut_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_en_i        (wr_en_i),
    .wr_data_i      (wr_data_i),
    .rd_data_o      (rd_data_o),
    .if_en_i        (if_en_i),
    .xfer_start_i   (xfer_start_i),
    .addr_mismatch_i(addr_mismatch_i),
    .scl_i          (scl_i),
    .sda_i          (sda_i),
    .so_latch_o     (so_latch_o),
    .sda_pull_o     (sda_pull_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en_i = 1'b1;
    wr_data_i = d;
    cyc(1);
    wr_en_i = 1'b0;
    wr_data_i = '0;
  endtask

  task automatic pulse_xfer();
    xfer_start_i = 1'b1;
    cyc(1);
    xfer_start_i = 1'b0;
  endtask

  task automatic pulse_mismatch();
    addr_mismatch_i = 1'b1;
    cyc(1);
    addr_mismatch_i = 1'b0;
  endtask

  task automatic lines(input logic scl, input logic sda);
    scl_i = scl;
    sda_i = sda;
    cyc(3);
  endtask

  task automatic t_reset();
    check("R1 reg", rd_data_o, 8'h00);
    check("R1 latch", {7'd0, so_latch_o}, 8'h01);
    check("R1 pull", {7'd0, sda_pull_o}, 8'h00);
  endtask

  task automatic t_storage();
    wr(8'h4C);
    check("R2 ro bits", rd_data_o, 8'h00);
    wr(8'hA0);
    check("R10 storage", rd_data_o, 8'hA0);
    wr(8'h00);
    check("R10 clear", rd_data_o, 8'h00);
  endtask

  task automatic t_triggers();
    wr(8'h02);
    check("R4 bit visible", rd_data_o, 8'h02);
    cyc(1);
    check("R4 self clear", rd_data_o, 8'h00);
    check("R4 latch low", {7'd0, so_latch_o}, 8'h00);
    wr(8'h01);
    check("R3 bit visible", rd_data_o, 8'h01);
    cyc(1);
    check("R3 self clear", rd_data_o, 8'h00);
    check("R3 latch high", {7'd0, so_latch_o}, 8'h01);
    wr(8'h02);
    cyc(1);
    wr(8'h03);
    cyc(1);
    check("R4 both stop wins", {rd_data_o[7:1], so_latch_o}, 8'h01);
  endtask

  task automatic t_en_low();
    if_en_i = 1'b0;
    cyc(1);
    wr(8'h02);
    check("R5 trig ignored", rd_data_o, 8'h00);
    cyc(2);
    check("R5 latch kept", {7'd0, so_latch_o}, 8'h01);
    if_en_i = 1'b1;
    cyc(1);
  endtask

  task automatic t_detect();
    lines(1'b1, 1'b0);
    check("R7 start set", rd_data_o, 8'h08);
    lines(1'b1, 1'b1);
    check("R6 stop set, R7 start dropped", rd_data_o, 8'h04);
    pulse_xfer();
    check("R6 xfer clear", rd_data_o, 8'h00);
    lines(1'b1, 1'b0);
    check("R7 start set again", rd_data_o, 8'h08);
    pulse_xfer();
    check("R7 xfer clear", rd_data_o, 8'h00);
    lines(1'b0, 1'b0);
    lines(1'b0, 1'b1);
    lines(1'b0, 1'b0);
    check("R6 R7 scl low no event", rd_data_o, 8'h00);
    lines(1'b1, 1'b0);
    check("R6 R7 scl rise no event", rd_data_o, 8'h00);
    lines(1'b1, 1'b1);
    check("R6 stop set", rd_data_o, 8'h04);
    pulse_mismatch();
    check("R6 mismatch clear", rd_data_o, 8'h00);
    lines(1'b1, 1'b0);
    check("R7 start before en drop", rd_data_o, 8'h08);
    if_en_i = 1'b0;
    cyc(1);
    if_en_i = 1'b1;
    check("R7 en low clear", rd_data_o, 8'h00);
    if_en_i = 1'b0;
    lines(1'b1, 1'b1);
    check("R6 clear beats set", rd_data_o, 8'h00);
    if_en_i = 1'b1;
    cyc(1);
  endtask

  task automatic t_ack();
    wr(8'h10);
    check("R8 ack bit", rd_data_o, 8'h10);
    check("R8 pull on", {7'd0, sda_pull_o}, 8'h01);
    cyc(4);
    check("R8 pull held", {7'd0, sda_pull_o}, 8'h01);
    scl_i = 1'b0;
    cyc(2);
    check("R8 pull before fall seen", {7'd0, sda_pull_o}, 8'h01);
    cyc(1);
    check("R8 pull dropped", {7'd0, sda_pull_o}, 8'h00);
    lines(1'b1, 1'b1);
    wr(8'h10);
    pulse_xfer();
    check("R9 xfer with en high keeps", {7'd0, sda_pull_o}, 8'h01);
    if_en_i = 1'b0;
    cyc(1);
    pulse_xfer();
    check("R9 xfer with en low clears", rd_data_o, 8'h00);
    if_en_i = 1'b1;
    cyc(1);
    wr(8'h10);
    wr(8'h00);
    check("R8 write zero clears", {7'd0, sda_pull_o}, 8'h00);
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_ni = 1'b1;
    if_en_i = 1'b1;
    cyc(3);
    t_reset();
    t_storage();
    t_triggers();
    t_en_low();
    t_detect();
    t_ack();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule